// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind an 8-bit host register port. The host sets up each counter through a shared command register: it picks the counter, the order in which that counter's count bytes move over the 8-bit port, and one of three counting behaviours. Those behaviours are a level that rises when the count runs out, a one-tick low strobe when the count runs out, and a free-running square wave. Each counter drives one output pin. A shared count-enable input (`tickEn`) paces all three counters.

The host can freeze a snapshot of a running count and read it back byte by byte while the counter keeps going. A multi-counter snapshot command can also capture the count, a status byte, or both, for any set of counters in one write. Only counter 2 obeys a gate input. Counters 0 and 1 always count.

Top module: `pitTimer`

## Requirements
- R1: Offsets 0, 1 and 2 are the data ports of counters 0, 1 and 2. Offset 3 is the command register. Command bits 7:6 pick the counter, and the value 3 in that field turns the write into a snapshot command.
- R2: Command bits 5:4 set the byte order of a counter: 01 moves the low byte only (high byte loads as zero), 10 moves the high byte only (low byte loads as zero), and 11 moves the low byte then the high byte, for both writes and reads. The value 00 is a count-freeze command and leaves the counter's set-up unchanged.
- R3: A command write stops the counter, sets the status pending-load flag, and drives the output to its idle level: low for the terminal-count behaviour, high for the other two. The count takes effect on the first tick after its last byte is written, and that transfer clears the pending-load flag.
- R4: With command bits 3:1 = 000 (terminal count), or any code other than 011 and 100, the output stays low until the count reaches zero. It then stays high, and the count keeps wrapping.
- R5: Bits 3:1 = 100 (strobe): the output is high and goes low for exactly one tick when the count reaches zero. This happens once per loaded count.
- R6: Bits 3:1 = 011 (square wave): the count steps down by 2 per tick. Bit 0 of the loaded value is ignored. When the count would reach zero, the output toggles and the count reloads, so an even count N gives N/2 ticks high and then N/2 ticks low.
- R7: A loaded count of 0 acts as 65536.
- R8: A frozen count ignores the running counter until all of its bytes have been read. A second freeze command issued before then is ignored.
- R9: Snapshot command: bit 5 = 1 skips the count and bit 4 = 1 skips the status. Bits 1, 2 and 3 pick counters 0, 1 and 2. A counter holding both returns the status byte first, then the count.
- R10: The status byte is {output level, pending-load flag, the counter's stored command bits 5:0}.
- R11: Counter 2 decrements only while `gate2` is high. The transfer of a newly written count does not wait for the gate.
- R12: After reset, all outputs are low, all counts are zero, the stored command bits are zero and the pending-load flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count-enable strobe shared by all counters |
| gate2 | input | 1 | Count gate for counter 2 |
| busAddr | input | 2 | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; advances the byte order and releases frozen values |
| busRdData | output | 8 | Read data for the addressed data port (0xFF at offset 3) |
| timerOut | output | 3 | Counter output levels |

## Verification
The hardest case to reach from the ports is a frozen count that must ignore a running counter: the bench freezes counter 1 in square-wave mode, ticks it further, and issues a second freeze before reading. A fresh freeze after the reads must then show that the count moved on. The pending-load flag and the ungated load transfer need a snapshot taken between the last count byte and the next tick while `gate2` is low. The 65536 case needs a zero load run through the full period.

// File: rtl/pitPkg.sv
package pitPkg;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CW_W   = 6;

  localparam logic [2:0] MODE_TC  = 3'b000;
  localparam logic [2:0] MODE_SQ  = 3'b011;
  localparam logic [2:0] MODE_STB = 3'b100;

  typedef enum logic [1:0] {
    RW_FREEZE = 2'b00,
    RW_LO     = 2'b01,
    RW_HI     = 2'b10,
    RW_WORD   = 2'b11
  } rwMode_t;

  typedef struct packed {
    logic ctrlWr;
    logic latchCnt;
    logic latchStat;
    logic dataWr;
    logic dataRd;
  } chanStrobe_t;

  function automatic logic idleLevel(input logic [2:0] m);
    return (m == MODE_SQ) || (m == MODE_STB);
  endfunction
endpackage

// File: rtl/pitCtrl.sv
module pitCtrl
  import pitPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output chanStrobe_t       stb [NUM_CH]
);
  localparam logic [1:0] CMD_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL   = 2'd3;

  logic cmdWr;
  logic isRb;
  logic [1:0] sel;
  logic [1:0] rw;
  logic [NUM_CH-1:0] ctrlVec;

  assign cmdWr = busWr && (busAddr == CMD_ADDR);
  assign sel   = busWrData[7:6];
  assign rw    = busWrData[5:4];
  assign isRb  = (sel == RB_SEL);

  for (genvar i = 0; i < NUM_CH; i++) begin : gStb
    logic hit;
    logic rbPick;
    assign hit    = cmdWr && !isRb && (sel == 2'(i));
    assign rbPick = cmdWr && isRb && busWrData[1+i];
    assign stb[i].ctrlWr    = hit && (rw != RW_FREEZE);
    assign stb[i].latchCnt  = (hit && (rw == RW_FREEZE)) || (rbPick && !busWrData[5]);
    assign stb[i].latchStat = rbPick && !busWrData[4];
    assign stb[i].dataWr    = busWr && (busAddr == 2'(i));
    assign stb[i].dataRd    = busRd && (busAddr == 2'(i));
    assign ctrlVec[i]       = stb[i].ctrlWr;
  end

  // R1: one command write reconfigures at most one counter
  a_r1_single_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlVec));

  // R9: a snapshot command never reconfigures a counter
  a_r9_rb_no_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == CMD_ADDR && busWrData[7:6] == RB_SEL) |-> (ctrlVec == '0));
endmodule

// File: rtl/pitChannel.sv
module pitChannel
  import pitPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gateIn,
  input  chanStrobe_t       stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              outLvl
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CW_W-1:0]   ctrlReg;
  logic [CNT_W-1:0]  countReg, ce, latchVal, curVal, reloadVal;
  logic [BYTE_W-1:0] lowTmp, statVal;
  logic wrHigh, rdHigh, loadPend, running, nullCnt;
  logic latchValid, statValid, armed, outQ;
  rwMode_t rw;
  logic [2:0] mode;
  logic isSq, isStb, isTc, stepOk;

  assign rw        = rwMode_t'(ctrlReg[5:4]);
  assign mode      = ctrlReg[3:1];
  assign isSq      = (mode == MODE_SQ);
  assign isStb     = (mode == MODE_STB);
  assign isTc      = !isSq && !isStb;
  assign reloadVal = isSq ? {countReg[CNT_W-1:1], 1'b0} : countReg;
  assign stepOk    = tickEn && running && gateIn && !loadPend;
  assign outLvl    = outQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      countReg   <= '0;
      ce         <= '0;
      latchVal   <= '0;
      lowTmp     <= '0;
      statVal    <= '0;
      wrHigh     <= 1'b0;
      rdHigh     <= 1'b0;
      loadPend   <= 1'b0;
      running    <= 1'b0;
      nullCnt    <= 1'b1;
      latchValid <= 1'b0;
      statValid  <= 1'b0;
      armed      <= 1'b0;
      outQ       <= 1'b0;
    end else if (stb.ctrlWr) begin
      ctrlReg    <= wrData[CW_W-1:0];
      running    <= 1'b0;
      loadPend   <= 1'b0;
      nullCnt    <= 1'b1;
      wrHigh     <= 1'b0;
      rdHigh     <= 1'b0;
      latchValid <= 1'b0;
      statValid  <= 1'b0;
      armed      <= 1'b0;
      outQ       <= idleLevel(wrData[3:1]);
    end else begin
      // counting element
      if (tickEn && loadPend) begin
        ce       <= reloadVal;
        loadPend <= 1'b0;
        nullCnt  <= 1'b0;
        running  <= 1'b1;
        armed    <= 1'b1;
      end else if (stepOk) begin
        if (isSq) begin
          if (ce == TWO) begin
            ce   <= reloadVal;
            outQ <= ~outQ;
          end else begin
            ce <= ce - TWO;
          end
        end else begin
          ce <= ce - ONE;
          if (isStb && !outQ) outQ <= 1'b1;
          if (ce == ONE) begin
            if (isTc) outQ <= 1'b1;
            else if (armed) begin
              outQ  <= 1'b0;
              armed <= 1'b0;
            end
          end
        end
      end

      // count register writes
      if (stb.dataWr) begin
        unique case (rw)
          RW_LO: begin
            countReg <= {{(CNT_W-BYTE_W){1'b0}}, wrData};
            loadPend <= 1'b1;
            nullCnt  <= 1'b1;
            outQ     <= !isTc;
          end
          RW_HI: begin
            countReg <= {wrData, {(CNT_W-BYTE_W){1'b0}}};
            loadPend <= 1'b1;
            nullCnt  <= 1'b1;
            outQ     <= !isTc;
          end
          RW_WORD: begin
            if (!wrHigh) begin
              lowTmp <= wrData;
              wrHigh <= 1'b1;
            end else begin
              countReg <= {wrData, lowTmp};
              wrHigh   <= 1'b0;
              loadPend <= 1'b1;
              nullCnt  <= 1'b1;
              outQ     <= !isTc;
            end
          end
          default: ;
        endcase
      end

      // freeze captures
      if (stb.latchCnt && !latchValid) begin
        latchVal   <= ce;
        latchValid <= 1'b1;
      end
      if (stb.latchStat && !statValid) begin
        statVal   <= {outQ, nullCnt, ctrlReg};
        statValid <= 1'b1;
      end

      // host reads
      if (stb.dataRd) begin
        if (statValid) begin
          statValid <= 1'b0;
        end else if (rw == RW_WORD) begin
          rdHigh <= ~rdHigh;
          if (rdHigh) latchValid <= 1'b0;
        end else begin
          latchValid <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    curVal = latchValid ? latchVal : ce;
    if (statValid) rdData = statVal;
    else begin
      unique case (rw)
        RW_HI:   rdData = curVal[CNT_W-1:BYTE_W];
        RW_WORD: rdData = rdHigh ? curVal[CNT_W-1:BYTE_W] : curVal[BYTE_W-1:0];
        default: rdData = curVal[BYTE_W-1:0];
      endcase
    end
  end

  // R3: a command write halts counting and marks the load pending
  a_r3_ctrl_halts: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrlWr |=> (!running && nullCnt));

  // R4: once high, the terminal-count output holds until reconfigured
  a_r4_tc_holds: assert property (@(posedge clk) disable iff (!rstN)
    (isTc && outQ && !stb.ctrlWr && !stb.dataWr) |=> outQ);

  // R5: the strobe low lasts one counted tick
  a_r5_strobe_one_tick: assert property (@(posedge clk) disable iff (!rstN)
    (isStb && !outQ && stepOk && !stb.ctrlWr && !stb.dataWr) |=> outQ);

  // R6: square-wave count steps by two
  a_r6_step_two: assert property (@(posedge clk) disable iff (!rstN)
    (isSq && stepOk && ce != TWO && !stb.ctrlWr) |=> (ce == CNT_W'($past(ce) - TWO)));

  // R8: a frozen value does not follow the counter
  a_r8_latch_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (latchValid && !stb.ctrlWr) |=> $stable(latchVal));

  // R11: gate low holds the count
  a_r11_gate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !gateIn && running && !loadPend && !stb.ctrlWr) |=> $stable(ce));
endmodule

// File: rtl/pitTimer.sv
module pitTimer
  import pitPkg::*;
#(
  parameter logic [NUM_CH-1:0] GATE_MASK = 3'b100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              gate2,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [BYTE_W-1:0] busRdData,
  output logic [NUM_CH-1:0] timerOut
);
  chanStrobe_t       stb   [NUM_CH];
  logic [BYTE_W-1:0] chRd  [NUM_CH];

  pitCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .stb       (stb)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic gateSel;
    if (GATE_MASK[i]) begin : gGated
      assign gateSel = gate2;
    end else begin : gFree
      assign gateSel = 1'b1;
    end
    pitChannel uCh (
      .clk    (clk),
      .rstN   (rstN),
      .tickEn (tickEn),
      .gateIn (gateSel),
      .stb    (stb[i]),
      .wrData (busWrData),
      .rdData (chRd[i]),
      .outLvl (timerOut[i])
    );
  end

  always_comb begin
    busRdData = '1;
    for (int i = 0; i < NUM_CH; i++)
      if (busAddr == 2'(i)) busRdData = chRd[i];
  end
endmodule

// File: tb/pitTimer_test.sv
module pitTimer_test;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TK = 3'd2, OP_OUT = 3'd3, OP_GT = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  addr;
    logic [7:0]  data;
    logic [16:0] n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 60;
  localparam vec_t VECS [NV] = '{
    // R4 terminal count on counter 0, R2 word order
    '{OP_WR, 2'd3, 8'h30, 17'd0, 4'd1},  // R1
    '{OP_WR, 2'd0, 8'h05, 17'd0, 4'd2},
    '{OP_WR, 2'd0, 8'h00, 17'd0, 4'd2},
    '{OP_OUT,2'd0, 8'h00, 17'd0, 4'd3},  // R3
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd3},
    '{OP_RD, 2'd0, 8'h05, 17'd0, 4'd2},  // R2
    '{OP_RD, 2'd0, 8'h00, 17'd0, 4'd2},
    '{OP_TK, 2'd0, 8'h00, 17'd4, 4'd4},
    '{OP_OUT,2'd0, 8'h00, 17'd0, 4'd4},  // R4
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd4},
    '{OP_OUT,2'd0, 8'h01, 17'd0, 4'd4},
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd4},
    '{OP_OUT,2'd0, 8'h01, 17'd0, 4'd4},
    '{OP_RD, 2'd0, 8'hFF, 17'd0, 4'd4},
    '{OP_RD, 2'd0, 8'hFF, 17'd0, 4'd4},
    // R3 command write halts counter 0
    '{OP_WR, 2'd3, 8'h30, 17'd0, 4'd3},
    '{OP_OUT,2'd0, 8'h00, 17'd0, 4'd3},
    '{OP_TK, 2'd0, 8'h00, 17'd3, 4'd3},
    '{OP_RD, 2'd0, 8'hFF, 17'd0, 4'd3},
    '{OP_RD, 2'd0, 8'hFF, 17'd0, 4'd3},
    // R6 square wave on counter 1, R8 freeze
    '{OP_WR, 2'd3, 8'h76, 17'd0, 4'd6},
    '{OP_OUT,2'd1, 8'h01, 17'd0, 4'd3},
    '{OP_WR, 2'd1, 8'h0A, 17'd0, 4'd6},
    '{OP_WR, 2'd1, 8'h00, 17'd0, 4'd6},
    '{OP_TK, 2'd0, 8'h00, 17'd2, 4'd6},
    '{OP_WR, 2'd3, 8'h40, 17'd0, 4'd8},  // R8 freeze at 8
    '{OP_TK, 2'd0, 8'h00, 17'd2, 4'd8},
    '{OP_WR, 2'd3, 8'h40, 17'd0, 4'd8},  // ignored
    '{OP_RD, 2'd1, 8'h08, 17'd0, 4'd8},
    '{OP_RD, 2'd1, 8'h00, 17'd0, 4'd8},
    '{OP_WR, 2'd3, 8'h40, 17'd0, 4'd8},
    '{OP_RD, 2'd1, 8'h04, 17'd0, 4'd6},  // R6 stepped by two
    '{OP_RD, 2'd1, 8'h00, 17'd0, 4'd6},
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd6},
    '{OP_OUT,2'd1, 8'h01, 17'd0, 4'd6},
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd6},
    '{OP_OUT,2'd1, 8'h00, 17'd0, 4'd6},
    '{OP_TK, 2'd0, 8'h00, 17'd4, 4'd6},
    '{OP_OUT,2'd1, 8'h00, 17'd0, 4'd6},
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd6},
    '{OP_OUT,2'd1, 8'h01, 17'd0, 4'd6},
    // R5 strobe on counter 2, R10 status, R11 gate
    '{OP_GT, 2'd0, 8'h00, 17'd0, 4'd11},
    '{OP_WR, 2'd3, 8'h98, 17'd0, 4'd5},
    '{OP_WR, 2'd2, 8'h03, 17'd0, 4'd2},
    '{OP_WR, 2'd3, 8'hE8, 17'd0, 4'd9},
    '{OP_RD, 2'd2, 8'hD8, 17'd0, 4'd10}, // R10 pending load set
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd11},
    '{OP_WR, 2'd3, 8'hE8, 17'd0, 4'd9},
    '{OP_RD, 2'd2, 8'h98, 17'd0, 4'd10},
    '{OP_TK, 2'd0, 8'h00, 17'd3, 4'd11},
    '{OP_RD, 2'd2, 8'h03, 17'd0, 4'd11}, // R11 held while gate low
    '{OP_GT, 2'd0, 8'h01, 17'd0, 4'd11},
    '{OP_TK, 2'd0, 8'h00, 17'd2, 4'd5},
    '{OP_OUT,2'd2, 8'h01, 17'd0, 4'd5},
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd5},
    '{OP_OUT,2'd2, 8'h00, 17'd0, 4'd5},  // R5 strobe low
    '{OP_TK, 2'd0, 8'h00, 17'd1, 4'd5},
    '{OP_OUT,2'd2, 8'h01, 17'd0, 4'd5},
    '{OP_WR, 2'd3, 8'hC8, 17'd0, 4'd9},  // R9 status then count
    '{OP_RD, 2'd2, 8'h98, 17'd0, 4'd9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic gate2 = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busRdData;
  logic [2:0] timerOut;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pitTimer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gate2(gate2),
    .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .timerOut(timerOut)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic note(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busCheck(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    note(busRdData == exp, req, busRdData, exp);
    busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic outCheck(input int ch, input logic exp, input string req);
    @(negedge clk);
    #1;
    note(timerOut[ch] == exp, req, {7'd0, timerOut[ch]}, {7'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    outCheck(0, 1'b0, "R12"); outCheck(1, 1'b0, "R12"); outCheck(2, 1'b0, "R12");
    busCheck(2'd0, 8'h00, "R12");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      unique case (VECS[i].op)
        OP_WR:  busWrite(VECS[i].addr, VECS[i].data);
        OP_RD:  busCheck(VECS[i].addr, VECS[i].data, tag);
        OP_TK:  ticks(int'(VECS[i].n));
        OP_OUT: outCheck(int'(VECS[i].addr), VECS[i].data[0], tag);
        default: begin @(negedge clk); gate2 = VECS[i].data[0]; end
      endcase
    end

    // R9 remainder of the snapshot: low byte of 0xFFFF
    busCheck(2'd2, 8'hFF, "R9");

    // R2 high-byte-only access on counter 1
    busWrite(2'd3, 8'h60);
    busWrite(2'd1, 8'h02);
    ticks(1);
    busCheck(2'd1, 8'h02, "R2");

    // R9 count-only snapshot of all three counters, then run on
    busWrite(2'd3, 8'hDE);
    ticks(1);
    busCheck(2'd0, 8'hFF, "R9");
    busCheck(2'd0, 8'hFF, "R9");
    busCheck(2'd1, 8'h02, "R9");
    busCheck(2'd2, 8'hFE, "R9");
    busCheck(2'd1, 8'h01, "R9");  // live high byte after release: 0x01FF

    // R7 zero count gives 65536 ticks
    busWrite(2'd3, 8'h30);
    busWrite(2'd0, 8'h00);
    busWrite(2'd0, 8'h00);
    ticks(1);
    ticks(65535);
    outCheck(0, 1'b0, "R7");
    ticks(1);
    outCheck(0, 1'b1, "R7");

    // R12 reset mid-run, then R10 status after reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    outCheck(0, 1'b0, "R12"); outCheck(1, 1'b0, "R12"); outCheck(2, 1'b0, "R12");
    busWrite(2'd3, 8'hE2);
    busCheck(2'd0, 8'h40, "R10");

    report();
  end
endmodule